// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads a configuration bitstream into a downstream FPGA over a passive serial link. A single start strobe launches a fixed sequence. The block first pulses an active-low configuration request and confirms that the target answers with its active-low status line. It then waits, within a bounded window, for the status line to be released. After a short settle delay it shifts bitstream bytes out on a serial clock and a data line. The bytes come from a valid/ready byte stream.

Each byte carries its own bit-order flag. When the flag says the byte is not already least-significant-bit first, the block reverses the byte before shifting it. After the byte marked last, the block checks that the status line is still high and, if the done input is wired, that it is high. It then sends eight more clock pulses so that the target can start up. Every wait limit is a parameter in microseconds and is converted to cycles with a clock-frequency parameter. A fault ends the sequence with a latched error code.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_n_o is 1, dclk_o is 0, busy_o, done_o and s_ready_o are 0, and err_o is 0.
- R2: A start with partial_i low drives cfg_n_o low for exactly RST cycles. RST is RST_US·CLK_MHZ, raised to ceil(0.6·CLK_MHZ) if that is larger. If status_n_i is high in the last cycle of the pulse, cfg_n_o returns high and err_o becomes 2, with no serial clock.
- R3: The cycle after cfg_n_o rises is elapsed count 0. status_n_i is counted as ready only when it is high at an elapsed count of at least MIN (ST_MIN_US·CLK_MHZ). If it is not ready by count MAX (ST_MAX_US·CLK_MHZ), err_o becomes 2'd3 one cycle after count MAX, and no byte is requested.
- R4: When readiness is seen at elapsed count k, s_ready_o first rises k+1+GAP cycles after cfg_n_o rose, where GAP is ST2CK_US·CLK_MHZ. dclk_o only ever pulses while cfg_n_o is high.
- R5: Each accepted byte goes out as 8 bits. With lsb_first_i=1, s_data_i bit 0 goes first. With lsb_first_i=0, bit 7 goes first. The flag is taken together with each byte.
- R6: Every high phase of dclk_o lasts exactly HALF_CYCLES system clocks. data_o changes only when dclk_o falls or while dclk_o is low.
- R7: After the byte marked by s_last_i, a low status_n_i ends the run with err_o = 4 and no trailing clocks.
- R8: With HAS_DONE set, a low done_i after the last byte ends the run with err_o = 5 and no trailing clocks.
- R9: After the checks pass, eight more dclk_o pulses with data_o at 0 follow. Then done_o goes to 1 and dclk_o rests low.
- R10: A start with partial_i high sets err_o to 1 on the next cycle and never drives cfg_n_o low.
- R11: busy_o is 1 from the cycle after start until done or error. Starts while busy_o is high are ignored. err_o and done_o hold until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| partial_i | input | 1 | Start asks for partial reconfiguration (rejected) |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the last of the bitstream |
| lsb_first_i | input | 1 | Byte is already least-significant-bit first |
| s_ready_o | output | 1 | Block accepts a byte |
| cfg_n_o | output | 1 | Active-low configuration request |
| status_n_i | input | 1 | Active-low status from target |
| done_i | input | 1 | Configuration-done from target |
| dclk_o | output | 1 | Serial clock |
| data_o | output | 1 | Serial data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed |
| err_o | output | 3 | Error code (0 none, 1 partial, 2 no reset, 3 not ready, 4 config error, 5 done inactive) |

## Verification
The main sequence is run with status release delays below the minimum poll time, between the minimum and the maximum, exactly at the maximum, and one cycle past it. These cases separate a poll that starts too early, an off-by-one at the timeout, and a correct ready path. Random byte values, each with a random bit-order flag and random stalls on the valid line, separate a correct per-byte reversal from a reversal that is fixed for the whole run. They also separate it from reversing the wrong byte. Directed runs then inject a missing reset answer, a status drop after the data, a low done line, a partial request, and a start during shifting. Each of these must give its own code or be ignored.

// File: rtl/ps_cfg_master.sv
`timescale 1ns/1ps
module ps_cfg_master #(
  parameter int CLK_MHZ     = 100,
  parameter int RST_US      = 2,
  parameter int ST_MIN_US   = 268,
  parameter int ST_MAX_US   = 1506,
  parameter int ST2CK_US    = 2,
  parameter int HALF_CYCLES = 2,
  parameter bit HAS_DONE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  input  logic       lsb_first_i,
  output logic       s_ready_o,
  output logic       cfg_n_o,
  input  logic       status_n_i,
  input  logic       done_i,
  output logic       dclk_o,
  output logic       data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] err_o
);
  localparam int RSP_CYC = (600 * CLK_MHZ + 999) / 1000;
  localparam int RST_RAW = RST_US * CLK_MHZ;
  localparam int RST_CYC = (RST_RAW > RSP_CYC) ? RST_RAW : RSP_CYC;
  localparam int MIN_CYC = ST_MIN_US * CLK_MHZ;
  localparam int MAX_CYC = ST_MAX_US * CLK_MHZ;
  localparam int GAP_RAW = ST2CK_US * CLK_MHZ;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CW = $clog2(MAX_CYC + RST_CYC + GAP_CYC + 2);
  localparam int HW = $clog2(HALF_CYCLES + 1);
  localparam logic [CW-1:0] RST_M1 = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_CYC);
  localparam logic [CW-1:0] MAX_C  = CW'(MAX_CYC);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP_CYC - 1);
  localparam logic [HW-1:0] HALF_M1 = HW'(HALF_CYCLES - 1);

  localparam logic [2:0] E_NONE = 3'd0, E_PART = 3'd1, E_NORST = 3'd2,
                         E_NRDY = 3'd3, E_CFG  = 3'd4, E_DONE  = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_WAIT, S_GAP, S_LOAD, S_SHIFT, S_CHECK, S_DONE, S_ERR
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    ord;
  logic          last_q, tail_q;

  always_comb begin
    for (int i = 0; i < 8; i++)
      ord[i] = lsb_first_i ? s_data_i[i] : s_data_i[7-i];
  end

  assign busy_o    = !(st == S_IDLE || st == S_DONE || st == S_ERR);
  assign done_o    = (st == S_DONE);
  assign s_ready_o = (st == S_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cfg_n_o <= 1'b1;
      dclk_o  <= 1'b0;
      data_o  <= 1'b0;
      err_o   <= E_NONE;
      cnt     <= '0;
      hcnt    <= '0;
      bitn    <= '0;
      sh      <= '0;
      last_q  <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: begin
          if (start_i) begin
            if (partial_i) begin
              err_o <= E_PART;
              st    <= S_ERR;
            end else begin
              err_o   <= E_NONE;
              cfg_n_o <= 1'b0;
              cnt     <= RST_M1;
              st      <= S_RST;
            end
          end
        end
        S_RST: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cfg_n_o <= 1'b1;
            cnt     <= '0;
            if (status_n_i) begin
              err_o <= E_NORST;
              st    <= S_ERR;
            end else st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (status_n_i && cnt >= MIN_C) begin
            cnt <= GAP_M1;
            st  <= S_GAP;
          end else if (cnt >= MAX_C) begin
            err_o <= E_NRDY;
            st    <= S_ERR;
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= S_LOAD;
        end
        S_LOAD: begin
          if (s_valid_i) begin
            sh     <= ord;
            data_o <= ord[0];
            last_q <= s_last_i;
            tail_q <= 1'b0;
            bitn   <= '0;
            hcnt   <= HALF_M1;
            st     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (hcnt != '0) hcnt <= hcnt - 1'b1;
          else begin
            hcnt <= HALF_M1;
            if (!dclk_o) dclk_o <= 1'b1;
            else begin
              dclk_o <= 1'b0;
              if (bitn == 3'd7) begin
                if (tail_q)      st <= S_DONE;
                else if (last_q) st <= S_CHECK;
                else             st <= S_LOAD;
              end else begin
                bitn   <= bitn + 1'b1;
                sh     <= sh >> 1;
                data_o <= sh[1];
              end
            end
          end
        end
        S_CHECK: begin
          if (!status_n_i) begin
            err_o <= E_CFG;
            st    <= S_ERR;
          end else if (HAS_DONE && !done_i) begin
            err_o <= E_DONE;
            st    <= S_ERR;
          end else begin
            sh     <= '0;
            data_o <= 1'b0;
            bitn   <= '0;
            hcnt   <= HALF_M1;
            tail_q <= 1'b1;
            st     <= S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps_cfg_master_chk.sv
`timescale 1ns/1ps
module ps_cfg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       partial_i,
  input logic       s_ready_o,
  input logic       cfg_n_o,
  input logic       dclk_o,
  input logic       data_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_o
);
  p_partial_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && partial_i && !busy_o) |=> (cfg_n_o && err_o == 3'd1));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));

  p_clk_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !dclk_o);

  p_clk_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_o |-> cfg_n_o);

  p_done_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == 3'd0 && !busy_o));

  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> busy_o);

  p_noreset_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == 3'd2) |-> cfg_n_o);
endmodule

bind ps_cfg_master ps_cfg_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
  .s_ready_o(s_ready_o), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o), .data_o(data_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/test_ps_cfg_master.sv
`timescale 1ns/1ps
module test_ps_cfg_master;
  localparam int HALF = 2;
  localparam int RSTC = 2;
  localparam int MINC = 20;
  localparam int MAXC = 60;
  localparam int GAPC = 3;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, partial_i = 0, s_valid_i = 0, s_last_i = 0, lsb_first_i = 0, done_i = 0;
  logic [7:0] s_data_i = 0;
  logic s_ready_o, cfg_n_o, dclk_o, data_o, busy_o, done_o, status_n_i;
  logic [2:0] err_o;

  int st_delay = 0;
  bit st_no_reset = 0, st_drop = 0;
  int rel_cnt = 1000000;

  assign status_n_i = st_drop ? 1'b0 : (!cfg_n_o ? st_no_reset : (rel_cnt >= st_delay));

  ps_cfg_master #(.CLK_MHZ(1), .RST_US(2), .ST_MIN_US(MINC), .ST_MAX_US(MAXC),
                  .ST2CK_US(GAPC), .HALF_CYCLES(HALF), .HAS_DONE(1'b1)) i_ps_cfg_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
    .lsb_first_i(lsb_first_i), .s_ready_o(s_ready_o), .cfg_n_o(cfg_n_o),
    .status_n_i(status_n_i), .done_i(done_i), .dclk_o(dclk_o), .data_o(data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int nbits, hw_bad, dst_bad, low_run, hi_run, rel_cyc, rdy_cyc, err_cyc;
  bit prev_dclk = 0, prev_cfg = 1, prev_data = 0, rdy_seen;
  bit bits [0:1023];
  bit eb   [0:1023];

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!cfg_n_o) rel_cnt <= 0;
    else if (rel_cnt < 1000000) rel_cnt <= rel_cnt + 1;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected <= 150000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (dclk_o && !prev_dclk && nbits < 1024) begin bits[nbits] = data_o; nbits++; end
    if (dclk_o) hi_run++;
    else if (prev_dclk) begin if (hi_run != HALF) hw_bad++; hi_run = 0; end
    if (dclk_o && prev_dclk && data_o != prev_data) dst_bad++;
    if (!cfg_n_o) low_run++;
    if (cfg_n_o && !prev_cfg) rel_cyc = cyc;
    if (s_ready_o && !rdy_seen) begin rdy_seen = 1; rdy_cyc = cyc; end
    if (err_o != 0 && err_cyc < 0) err_cyc = cyc;
    prev_dclk = dclk_o; prev_cfg = cfg_n_o; prev_data = data_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic clear_mon();
    nbits = 0; hw_bad = 0; dst_bad = 0; low_run = 0; hi_run = 0;
    rel_cyc = -1; rdy_cyc = -1; err_cyc = -1; rdy_seen = 0;
  endtask

  task automatic send(input bit [7:0] b, input bit l, input bit last);
    s_data_i = b; lsb_first_i = l; s_last_i = last; s_valid_i = 1;
    while (!s_ready_o) @(negedge clk);
    @(negedge clk);
    s_valid_i = 0; s_last_i = 0;
  endtask

  function automatic int ready_delay(input int d);
    return ((d > MINC) ? d : MINC) + 1 + GAPC;
  endfunction

  task automatic pulse_start(input bit part);
    @(negedge clk); start_i = 1; partial_i = part;
    @(negedge clk); start_i = 0; partial_i = 0;
  endtask

  task automatic run_cfg(input int n, input int d, input bit drop, input bit dn, input int exp_err);
    int ne = 0, mm = 0, tz = 0;
    clear_mon(); st_delay = d; st_drop = 0; st_no_reset = 0; done_i = 0;
    pulse_start(0);
    chk(busy_o && err_o == 0 && !done_o, "R11 busy set, code cleared by start", err_o, 0);
    if (d <= MAXC) begin
      for (int i = 0; i < n; i++) begin
        bit [7:0] b = 8'($urandom);
        bit l = 1'($urandom_range(0, 1));
        repeat ($urandom_range(0, 3)) @(negedge clk);
        for (int k = 0; k < 8; k++) begin eb[ne] = l ? b[k] : b[7-k]; ne++; end
        if (i == n - 1) done_i = dn;
        send(b, l, i == n - 1);
        if (i == 0) pulse_start(1);
        if (i == n - 1 && drop) st_drop = 1;
      end
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(err_o == 3'(exp_err), "R7 R8 R3 R11 final error code", err_o, exp_err);
    chk(low_run == RSTC, "R2 request pulse length", low_run, RSTC);
    chk(hw_bad == 0 && dst_bad == 0, "R6 clock phase and data hold", hw_bad + dst_bad, 0);
    if (exp_err == 0) begin
      for (int k = 0; k < ne; k++) if (bits[k] != eb[k]) mm++;
      for (int k = ne; k < ne + 8; k++) if (bits[k] != 0) tz++;
      chk(mm == 0, "R5 bit order per byte", mm, 0);
      chk(nbits == ne + 8 && tz == 0, "R9 eight trailing zero pulses", nbits, ne + 8);
      chk(done_o && !busy_o && !dclk_o, "R9 done after tail", done_o, 1);
      chk(rdy_cyc - rel_cyc == ready_delay(d), "R3 R4 poll window and settle gap",
          rdy_cyc - rel_cyc, ready_delay(d));
    end else if (exp_err == 3) begin
      chk(!rdy_seen, "R3 no byte requested on timeout", rdy_seen, 0);
      chk(err_cyc - rel_cyc == MAXC + 1, "R3 timeout cycle", err_cyc - rel_cyc, MAXC + 1);
    end else begin
      chk(nbits == ne && !done_o, "R7 R8 no trailing clocks after failed check", nbits, ne);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_n_o && !dclk_o && !busy_o && !done_o && !s_ready_o && err_o == 0,
        "R1 reset state", {cfg_n_o, dclk_o, busy_o, done_o, s_ready_o}, 5'b10000);

    run_cfg(4, 5, 0, 1, 0);
    run_cfg(6, 35, 0, 1, 0);
    run_cfg(2, MAXC, 0, 1, 0);
    for (int r = 0; r < 3; r++) run_cfg($urandom_range(1, 8), $urandom_range(0, 55), 0, 1, 0);

    run_cfg(3, MAXC + 1, 0, 1, 3);
    repeat (20) @(negedge clk);
    chk(err_o == 3 && !busy_o, "R11 error code held until next start", err_o, 3);

    clear_mon(); st_no_reset = 1; st_drop = 0;
    pulse_start(0);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(err_o == 2 && cfg_n_o, "R2 missing reset answer", err_o, 2);
    chk(low_run == RSTC && nbits == 0 && !rdy_seen, "R2 pulse then abort without clocks", low_run, RSTC);
    st_no_reset = 0;

    run_cfg(3, 10, 1, 1, 4);
    run_cfg(3, 10, 0, 0, 5);

    clear_mon(); st_drop = 0;
    pulse_start(1);
    chk(err_o == 1 && !busy_o, "R10 partial rejected", err_o, 1);
    repeat (10) @(negedge clk);
    chk(low_run == 0 && cfg_n_o && nbits == 0, "R10 request pin untouched", low_run, 0);

    run_cfg(2, 0, 0, 1, 0);
    summary();
  end
endmodule